// File: doc/BRIEF.md
# SCL Low-Time Timeout Monitor

This block guards an I2C controller against a bus hang in which the clock line is held low indefinitely. It samples the SCL line on the system clock and, on every one-cycle tick from the bit-period timebase, counts how many bus clock periods the line has stayed low. A programmable limit sets the threshold. When the count reaches the limit, a sticky timeout status bit is set.

Writing a limit of zero turns detection off. The status bit can always be read. A separate interrupt enable gates it onto the interrupt output. A write-one-to-clear strobe vector removes the status. That vector also carries the transmit-overflow and receive-overflow clear bits, which belong to neighbouring logic. Recovering the bus is left to other logic; this block only reports the hang.

Top module: `scl_lowtime_monitor`

## Requirements
- R1: After reset the limit readback is 0, the timeout status is 0, the interrupt enable readback is 0 and the interrupt output is 0.
- R2: A cycle with `limitWe` high loads `limitWdata` into the limit register, and `limitRd` shows the new value on the next cycle. The same write restarts the low-time count from zero.
- R3: While SCL is sampled low and the limit is nonzero, the count advances by one on each cycle in which `bitTick` is high. Cycles without `bitTick` do not advance it.
- R4: Any cycle in which SCL is sampled high resets the count to zero.
- R5: The timeout status becomes 1 at the clock edge that registers the Nth tick of a continuous low period, where N is the limit. It then stays 1 until it is cleared.
- R6: With a limit of zero, the status never sets, however long SCL stays low.
- R7: The status output reflects the event whatever the enable is. `irqOut` is 1 exactly when the status and the enable (written through `irqEnWe`/`irqEnWdata`, read on `irqEnRd`) are both 1.
- R8: `irqClear` bit 0 clears the timeout status at the next edge. Bit 1 (transmit overflow) and bit 2 (receive overflow) have no effect on it.
- R9: If the status is set and bit 0 of `irqClear` is pulsed in the same cycle, the status ends up 1.
- R10: Once the count has reached the limit it holds there. If SCL stays low after a clear, the status does not set again until SCL has gone high and a new low period reaches the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level, already synchronous to clk |
| bitTick | input | 1 | One-cycle pulse per bus clock period |
| limitWe | input | 1 | Limit register write strobe |
| limitWdata | input | LIMIT_W | Limit value to write (0 disables) |
| limitRd | output | LIMIT_W | Limit register readback |
| irqEnWe | input | 1 | Interrupt enable write strobe |
| irqEnWdata | input | 1 | Interrupt enable value |
| irqEnRd | output | 1 | Interrupt enable readback |
| irqClear | input | 3 | Write-one-to-clear: bit0 timeout, bit1 tx overflow, bit2 rx overflow |
| toStatus | output | 1 | Sticky timeout status |
| irqOut | output | 1 | Status AND enable |

## Verification
The bench builds the block with the default 20-bit limit. A limit of all ones can therefore be written and read back across the full field width, while every actual timeout is driven with small limits of 1 to 6 ticks. Those small limits reach the exact tick on which the status sets, the tick just before it, restarts caused by SCL going high, the hold at the limit, and a set coinciding with a clear within a few dozen cycles.

// File: rtl/scl_mon_pkg.sv
package scl_mon_pkg;
  // Strobes the control path sends to the datapath each cycle.
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } monStrobes_t;

  localparam int CLR_W = 3;
  localparam int CLR_TIMEOUT = 0;
endpackage

// File: rtl/scl_mon_datapath.sv
module scl_mon_datapath
  import scl_mon_pkg::*;
#(
  parameter int LIMIT_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               bitTick,
  input  logic               limitWe,
  input  logic [LIMIT_W-1:0] limitWdata,
  input  monStrobes_t        strb,
  output logic [LIMIT_W-1:0] limitRd,
  output logic               limitZero,
  output logic               atLimit,
  output logic               nearLimit
);
  localparam logic [LIMIT_W-1:0] ONE = LIMIT_W'(1);

  logic [LIMIT_W-1:0] limitQ;
  logic [LIMIT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) limitQ <= '0;
    else if (limitWe) limitQ <= limitWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntQ <= '0;
    else if (strb.cntClear) cntQ <= '0;
    else if (strb.cntInc) cntQ <= cntQ + ONE;
  end

  assign limitRd   = limitQ;
  assign limitZero = (limitQ == '0);
  assign atLimit   = (cntQ == limitQ);
  assign nearLimit = ((cntQ + ONE) == limitQ);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= limitQ);  // R10
  AST_HIGH_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    sclIn |=> (cntQ == '0));  // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (limitQ == '0) |-> (cntQ == '0));  // R6
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !sclIn && !limitWe) |=> $stable(cntQ));  // R3
endmodule

// File: rtl/scl_mon_control.sv
module scl_mon_control
  import scl_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             bitTick,
  input  logic             limitWe,
  input  logic             limitZero,
  input  logic             atLimit,
  input  logic             nearLimit,
  input  logic             irqEnWe,
  input  logic             irqEnWdata,
  input  logic [CLR_W-1:0] irqClear,
  output monStrobes_t      strb,
  output logic             statusQ,
  output logic             irqEnQ,
  output logic             irqOut
);
  logic setEvent;

  always_comb begin
    strb.cntClear = sclIn | limitZero | limitWe;
    strb.cntInc   = bitTick & ~atLimit & ~strb.cntClear;
    setEvent      = strb.cntInc & nearLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= 1'b0;
    else if (setEvent) statusQ <= 1'b1;
    else if (irqClear[CLR_TIMEOUT]) statusQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqEnQ <= 1'b0;
    else if (irqEnWe) irqEnQ <= irqEnWdata;
  end

  assign irqOut = statusQ & irqEnQ;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setEvent |=> statusQ);  // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !irqClear[CLR_TIMEOUT]) |=> statusQ);  // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear[CLR_TIMEOUT] && !setEvent) |=> !statusQ);  // R8
  AST_DISABLED_NOSET: assert property (@(posedge clk) disable iff (!rstN)
    (limitZero && !statusQ && !limitWe) |=> !statusQ);  // R6
endmodule

// File: rtl/scl_lowtime_monitor.sv
module scl_lowtime_monitor
  import scl_mon_pkg::*;
#(
  parameter int LIMIT_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               bitTick,
  input  logic               limitWe,
  input  logic [LIMIT_W-1:0] limitWdata,
  output logic [LIMIT_W-1:0] limitRd,
  input  logic               irqEnWe,
  input  logic               irqEnWdata,
  output logic               irqEnRd,
  input  logic [2:0]         irqClear,
  output logic               toStatus,
  output logic               irqOut
);
  monStrobes_t strb;
  logic limitZero, atLimit, nearLimit;

  scl_mon_datapath #(.LIMIT_W(LIMIT_W)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .bitTick(bitTick),
    .limitWe(limitWe), .limitWdata(limitWdata), .strb(strb),
    .limitRd(limitRd), .limitZero(limitZero), .atLimit(atLimit),
    .nearLimit(nearLimit)
  );

  scl_mon_control uCtl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .bitTick(bitTick),
    .limitWe(limitWe), .limitZero(limitZero), .atLimit(atLimit),
    .nearLimit(nearLimit), .irqEnWe(irqEnWe), .irqEnWdata(irqEnWdata),
    .irqClear(irqClear), .strb(strb), .statusQ(toStatus),
    .irqEnQ(irqEnRd), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_scl_lowtime_monitor.sv
module tb_scl_lowtime_monitor;
  localparam int W = 20;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, bitTick = 1'b0, limitWe = 1'b0, irqEnWe = 1'b0, irqEnWdata = 1'b0;
  logic [W-1:0] limitWdata = '0;
  logic [2:0] irqClear = '0;
  logic [W-1:0] limitRd;
  logic irqEnRd, toStatus, irqOut;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  scl_lowtime_monitor #(.LIMIT_W(W)) dut (.*);

  // {limit[19:0], lowTicks[7:0], expectedStatus}
  localparam logic [28:0] VEC [0:7] = '{
    {20'd1, 8'd1, 1'b1}, {20'd3, 8'd2, 1'b0}, {20'd3, 8'd3, 1'b1},
    {20'd5, 8'd4, 1'b0}, {20'd5, 8'd9, 1'b1}, {20'd0, 8'd12, 1'b0},
    {20'd6, 8'd6, 1'b1}, {20'd2, 8'd0, 1'b0}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic tick();
    bitTick = 1'b1; cyc(); bitTick = 1'b0; cyc();
  endtask

  task automatic setLimit(input logic [W-1:0] v);
    limitWdata = v; limitWe = 1'b1; cyc(); limitWe = 1'b0;
  endtask

  task automatic clr(input logic [2:0] v);
    irqClear = v; cyc(); irqClear = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc(); rstN = 1'b1; cyc();
    chk("R1 limit", limitRd, 0);
    chk("R1 status", toStatus, 0);
    chk("R1 enable", irqEnRd, 0);
    chk("R1 irq", irqOut, 0);

    // table walk: status after N ticks of low
    for (int i = 0; i < 8; i++) begin
      sclIn = 1'b1; setLimit(VEC[i][28:9]); clr(3'b001);
      sclIn = 1'b0; cyc();
      for (int t = 0; t < int'(VEC[i][8:1]); t++) tick();
      chk($sformatf("R5/R6 vector %0d", i), toStatus, VEC[i][0]);
    end
    sclIn = 1'b1; cyc();

    // R2 readback full width
    setLimit('1); cyc();
    chk("R2 readback max", limitRd, 32'hFFFFF);
    setLimit(20'd4); cyc();
    chk("R2 readback small", limitRd, 4);

    // R2 limit write restarts the count
    clr(3'b001); sclIn = 1'b0; cyc();
    tick(); tick(); tick();
    setLimit(20'd4); tick();
    chk("R2 restart after write", toStatus, 0);
    tick(); tick(); tick();
    chk("R2 fires after fresh count", toStatus, 1);

    // R3 no tick, no count
    sclIn = 1'b1; cyc(); clr(3'b001); sclIn = 1'b0;
    repeat (40) cyc();
    chk("R3 idle cycles ignored", toStatus, 0);
    tick(); tick(); tick();
    chk("R3 one before limit", toStatus, 0);
    tick();
    chk("R3 at limit", toStatus, 1);

    // R4 high resets count
    sclIn = 1'b1; cyc(); clr(3'b001); sclIn = 1'b0; cyc();
    tick(); tick(); tick();
    sclIn = 1'b1; cyc(); sclIn = 1'b0; cyc();
    tick(); tick(); tick();
    chk("R4 restart on high", toStatus, 0);
    tick();
    chk("R4 new period fires", toStatus, 1);

    // R10 held at limit, no refire while still low
    clr(3'b001);
    repeat (6) tick();
    chk("R10 no refire while low", toStatus, 0);
    sclIn = 1'b1; cyc(); sclIn = 1'b0; cyc();
    repeat (4) tick();
    chk("R10 refire after new low", toStatus, 1);

    // R7 enable gating
    chk("R7 status w/o enable", toStatus, 1);
    chk("R7 irq masked", irqOut, 0);
    irqEnWdata = 1'b1; irqEnWe = 1'b1; cyc(); irqEnWe = 1'b0;
    chk("R7 enable readback", irqEnRd, 1);
    chk("R7 irq asserted", irqOut, 1);

    // R8 other clear bits, then timeout clear
    clr(3'b110);
    chk("R8 overflow bits no effect", toStatus, 1);
    clr(3'b001);
    chk("R8 w1c clears", toStatus, 0);
    chk("R8 irq drops", irqOut, 0);

    // R9 set and clear same cycle
    sclIn = 1'b1; cyc(); sclIn = 1'b0; cyc();
    repeat (3) tick();
    bitTick = 1'b1; irqClear = 3'b001; cyc(); bitTick = 1'b0; irqClear = '0; cyc();
    chk("R9 set wins", toStatus, 1);

    // R6 zero limit disables even with long low
    sclIn = 1'b1; setLimit('0); clr(3'b001); sclIn = 1'b0;
    repeat (30) tick();
    chk("R6 disabled", toStatus, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule